// File: doc/BRIEF.md
# Automatic MDI/MDIX crossover controller

This block decides, for one twisted-pair port, whether the transmit and receive pairs are used straight (MDI) or swapped (MDIX). It does this before auto-negotiation starts, so that link pulses travel on the right pairs. In automatic mode it keeps a configuration for one timed evaluation window and watches the receive channel. If link pulses or data appear in that window, the configuration is kept. If nothing appears, an 11-bit pseudo-random shift register advances one step, and its new bit decides whether the configuration flips. Because each end of the link makes its own random choices, two ends that are both hunting do not stay in step.

A decision is never applied while a link pulse is being transmitted. When the window expires during transmission, the decision waits until the busy flag clears. A manual mode forces either mapping directly. When manual mode is released, hunting resumes from the configuration that was forced. While the block holds on a link, one full window without activity sends it back to hunting.

Top module: `mdix_ctrl`

## Requirements
- R1: After reset, `xover_o` is 0 (MDI), `link_hold_o` is 0, and the shift register holds the nonzero seed 11'h5A5.
- R2: `xover_o` = 1 means the pairs are swapped (MDIX), and `xover_o` = 0 means the straight mapping (MDI).
- R3: The evaluation window is EVAL_CYCLES clock cycles long. In automatic mode the outputs change only on the EVAL_CYCLES-th rising edge counted from reset release, from the previous decision or from manual release, and only when `tx_busy_i` is low at that edge.
- R4: If `link_act_i` is high on any edge of the window, even a single one, the decision keeps `xover_o` and sets `link_hold_o` to 1.
- R5: If the block is hunting and the window passes with no activity, the register steps as q <= {q[9:0], q[10]^q[8]} (polynomial x^11 + x^9 + 1). `xover_o` inverts exactly when the new bit is 1.
- R6: While `tx_busy_i` is high at an expired window, the decision is deferred and `xover_o` and `link_hold_o` do not change. The decision is taken on the first edge where `tx_busy_i` is low.
- R7: If the block is holding and a full window passes with no activity, `link_hold_o` returns to 0. `xover_o` is kept and the register does not step.
- R8: While `man_en_i` is high, `xover_o` takes `man_mdix_i` one edge later and `link_hold_o` is 0, whatever the state of `tx_busy_i`. The shift register does not step and the window timer is held at its start.
- R9: After `man_en_i` falls, hunting resumes from the forced value, with a full window before the first decision.
- R10: The shift register never holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_act_i | input | 1 | Link pulses or data seen on the receive channel |
| tx_busy_i | input | 1 | A link pulse is being transmitted |
| man_en_i | input | 1 | Manual crossover mode enable |
| man_mdix_i | input | 1 | Forced mapping in manual mode (1 = MDIX) |
| xover_o | output | 1 | Pair multiplexer select (1 = MDIX) |
| link_hold_o | output | 1 | Status: holding a configuration on detected activity |

## Verification
The window expiry and the transmit-busy flag can both apply on the same edge. In that case the decision must be held back rather than taken. The bench provokes this by keeping `tx_busy_i` high across the whole window and for one to three cycles after expiry. On every held cycle it checks that neither output moves, and after the flag drops it checks that the decision appears exactly one edge later, with the value predicted by its own register model. Manual override combined with a high busy flag is also driven, to show that forcing is not gated by transmission.

// File: rtl/mdix_pkg.sv
package mdix_pkg;
   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_HOLD = 1'b1
   } mdix_state_e;
endpackage

// File: rtl/mdix_lfsr.sv
module mdix_lfsr #(
   parameter int            W        = 11,
   parameter logic [W-1:0]  TAP_MASK = 11'b101_0000_0000,
   parameter logic [W-1:0]  SEED     = 11'h5A5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] q_o,
   output logic         next_bit_o
);
   logic [W-1:0] q;
   logic [W-1:0] tapped;

   if (W < 2) begin : g_bad_w
      $error("mdix_lfsr: W must be at least 2");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("mdix_lfsr: SEED must be nonzero");
   end
   if (TAP_MASK[W-1] == 1'b0) begin : g_bad_taps
      $error("mdix_lfsr: top bit must be a tap");
   end

   for (genvar i = 0; i < W; i++) begin : g_tap
      assign tapped[i] = q[i] & TAP_MASK[i];
   end

   assign next_bit_o = ^tapped;
   assign q_o        = q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= SEED;
      end else if (step_i) begin
         q <= {q[W-2:0], next_bit_o};
      end
   end
endmodule

// File: rtl/mdix_timer.sv
module mdix_timer #(
   parameter int EVAL_CYCLES = 7_500_000,
   localparam int CNT_W = (EVAL_CYCLES > 1) ? $clog2(EVAL_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   output logic             done_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(EVAL_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   if (EVAL_CYCLES < 2) begin : g_bad_eval
      $error("mdix_timer: EVAL_CYCLES must be at least 2");
   end

   assign done_o = (cnt == LAST);
   assign cnt_o  = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear_i) begin
         cnt <= '0;
      end else if (!done_o) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdix_fsm.sv
module mdix_fsm
   import mdix_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic link_act_i,
   input  logic tx_busy_i,
   input  logic man_en_i,
   input  logic man_mdix_i,
   input  logic win_done_i,
   input  logic rnd_bit_i,
   output logic rnd_step_o,
   output logic win_clear_o,
   output logic xover_o,
   output logic hold_o
);
   mdix_state_e state;
   logic        seen;
   logic        xover;
   logic        decide;
   logic        act_any;

   assign decide      = win_done_i & ~tx_busy_i & ~man_en_i;
   assign act_any     = seen | link_act_i;
   assign rnd_step_o  = decide & (state == ST_HUNT) & ~act_any;
   assign win_clear_o = man_en_i | decide;
   assign xover_o     = xover;
   assign hold_o      = (state == ST_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HUNT;
         seen  <= 1'b0;
         xover <= 1'b0;
      end else if (man_en_i) begin
         state <= ST_HUNT;
         seen  <= 1'b0;
         xover <= man_mdix_i;
      end else if (decide) begin
         seen  <= 1'b0;
         state <= act_any ? ST_HOLD : ST_HUNT;
         if (rnd_step_o && rnd_bit_i) begin
            xover <= ~xover;
         end
      end else begin
         seen <= act_any;
      end
   end
endmodule

// File: rtl/mdix_ctrl.sv
module mdix_ctrl #(
   parameter int            EVAL_CYCLES = 7_500_000,
   parameter int            LFSR_W      = 11,
   parameter logic [10:0]   LFSR_TAPS   = 11'b101_0000_0000,
   parameter logic [10:0]   LFSR_SEED   = 11'h5A5,
   localparam int           CNT_W       = (EVAL_CYCLES > 1) ? $clog2(EVAL_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_act_i,
   input  logic tx_busy_i,
   input  logic man_en_i,
   input  logic man_mdix_i,
   output logic xover_o,
   output logic link_hold_o
);
   logic             tmr_done;
   logic             tmr_clear;
   logic [CNT_W-1:0] tmr_cnt;
   logic [LFSR_W-1:0] lfsr_q;
   logic             lfsr_bit;
   logic             lfsr_step;

   if (LFSR_W != 11) begin : g_bad_lfsr
      $error("mdix_ctrl: the tap set is defined for an 11-bit register");
   end

   mdix_timer #(.EVAL_CYCLES(EVAL_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (tmr_clear),
      .done_o  (tmr_done),
      .cnt_o   (tmr_cnt)
   );

   mdix_lfsr #(.W(LFSR_W), .TAP_MASK(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (lfsr_step),
      .q_o        (lfsr_q),
      .next_bit_o (lfsr_bit)
   );

   mdix_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_act_i  (link_act_i),
      .tx_busy_i   (tx_busy_i),
      .man_en_i    (man_en_i),
      .man_mdix_i  (man_mdix_i),
      .win_done_i  (tmr_done),
      .rnd_bit_i   (lfsr_bit),
      .rnd_step_o  (lfsr_step),
      .win_clear_o (tmr_clear),
      .xover_o     (xover_o),
      .hold_o      (link_hold_o)
   );
endmodule

// File: rtl/mdix_ctrl_chk.sv
module mdix_ctrl_chk #(
   parameter int EVAL_CYCLES = 8,
   parameter int LFSR_W      = 11,
   parameter int CNT_W       = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_busy_i,
   input logic              man_en_i,
   input logic              man_mdix_i,
   input logic              xover_o,
   input logic              link_hold_o,
   input logic              tmr_done,
   input logic [CNT_W-1:0]  tmr_cnt,
   input logic [LFSR_W-1:0] lfsr_q
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(EVAL_CYCLES - 1);

   a_r10_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

   a_r3_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_cnt <= LAST);

   a_r3_no_early_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_done && !man_en_i) |=> ($stable(xover_o) && $stable(link_hold_o)));

   a_r6_busy_defers: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy_i && !man_en_i) |=> ($stable(xover_o) && $stable(link_hold_o)));

   a_r8_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
      man_en_i |=> (xover_o == $past(man_mdix_i) && !link_hold_o));

   a_r8_manual_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
      man_en_i |=> (tmr_cnt == '0));

   a_r7_hold_keeps_config: assert property (@(posedge clk) disable iff (!rst_n)
      (link_hold_o && !man_en_i) |=> $stable(xover_o));
endmodule

bind mdix_ctrl mdix_ctrl_chk #(
   .EVAL_CYCLES (EVAL_CYCLES),
   .LFSR_W      (LFSR_W),
   .CNT_W       (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_busy_i   (tx_busy_i),
   .man_en_i    (man_en_i),
   .man_mdix_i  (man_mdix_i),
   .xover_o     (xover_o),
   .link_hold_o (link_hold_o),
   .tmr_done    (tmr_done),
   .tmr_cnt     (tmr_cnt),
   .lfsr_q      (lfsr_q)
);

// File: tb/mdix_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdix_ctrl_tb_top;
   localparam int EVAL = 8;
   localparam int NVEC = 14;
   // entry: {mode[1:0], busy[2:0]}; mode 0 none, 1 whole window, 2 one-cycle pulse
   localparam logic [4:0] VEC [NVEC] = '{
      {2'd0, 3'd0}, {2'd0, 3'd2}, {2'd0, 3'd0}, {2'd1, 3'd0},
      {2'd1, 3'd3}, {2'd0, 3'd0}, {2'd0, 3'd1}, {2'd2, 3'd0},
      {2'd2, 3'd2}, {2'd0, 3'd0}, {2'd0, 3'd0}, {2'd0, 3'd3},
      {2'd0, 3'd0}, {2'd0, 3'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_act_i = 1'b0;
   logic tx_busy_i = 1'b0;
   logic man_en_i = 1'b0;
   logic man_mdix_i = 1'b0;
   logic xover_o;
   logic link_hold_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [10:0] m_q;
   logic        m_x;
   logic        m_h;

   always #2 clk = ~clk;

   mdix_ctrl #(.EVAL_CYCLES(EVAL)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_act_i  (link_act_i),
      .tx_busy_i   (tx_busy_i),
      .man_en_i    (man_en_i),
      .man_mdix_i  (man_mdix_i),
      .xover_o     (xover_o),
      .link_hold_o (link_hold_o)
   );

   task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {xover,hold} actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_q = 11'h5A5;
      m_x = 1'b0;
      m_h = 1'b0;
   endtask

   task automatic model_decide(bit act);
      logic fb;
      if (act) begin
         m_h = 1'b1;
      end else if (m_h) begin
         m_h = 1'b0;
      end else begin
         fb  = m_q[10] ^ m_q[8];
         m_q = {m_q[9:0], fb};
         if (fb) m_x = ~m_x;
      end
   endtask

   // starts at a negedge just after a decision, reset release or manual release
   task automatic run_win(int mode, int busy, string req);
      tx_busy_i = (busy != 0);
      for (int c = 0; c < EVAL - 1; c++) begin
         link_act_i = (mode == 1) || (mode == 2 && c == 3);
         @(negedge clk);
      end
      link_act_i = (mode == 1);
      chk("R3 window not yet decided", {xover_o, link_hold_o}, {m_x, m_h});
      for (int b = 0; b < busy; b++) begin
         @(negedge clk);
         chk("R6 decision held while busy", {xover_o, link_hold_o}, {m_x, m_h});
      end
      tx_busy_i = 1'b0;
      @(negedge clk);
      model_decide(mode != 0);
      chk(req, {xover_o, link_hold_o}, {m_x, m_h});
      link_act_i = 1'b0;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset state", {xover_o, link_hold_o}, 2'b00);
      rst_n = 1'b1;

      // table walk: R4 keeps on activity, R5 random step, R7 drop hold, R2 mapping
      for (int v = 0; v < NVEC; v++) begin
         run_win(int'(VEC[v][4:3]), int'(VEC[v][2:0]), "R4/R5/R7 window decision");
      end

      // R8: manual forcing, also while busy and while holding
      run_win(1, 0, "R4 hold before manual");
      tx_busy_i  = 1'b1;
      man_en_i   = 1'b1;
      man_mdix_i = 1'b1;
      @(negedge clk);
      chk("R8 manual MDIX while busy", {xover_o, link_hold_o}, 2'b10);
      man_mdix_i = 1'b0;
      @(negedge clk);
      chk("R8 manual MDI", {xover_o, link_hold_o}, 2'b00);
      man_mdix_i = 1'b1;
      tx_busy_i  = 1'b0;
      repeat (2 * EVAL) @(negedge clk);
      chk("R8 manual holds, no hunting", {xover_o, link_hold_o}, 2'b10);

      // R9: resume from forced value with a full window
      man_en_i = 1'b0;
      m_x = 1'b1;
      m_h = 1'b0;
      run_win(0, 0, "R9 first decision after release");
      run_win(0, 0, "R9 hunting continues");
      run_win(2, 1, "R9 pulse found after release");

      // R1: reset in mid-run restores seed and MDI
      for (int c = 0; c < 3; c++) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      model_reset();
      chk("R1 reset mid-run", {xover_o, link_hold_o}, 2'b00);
      rst_n = 1'b1;
      run_win(0, 0, "R1 seed reloaded, first step");
      run_win(0, 0, "R1 seed reloaded, second step");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule